// File: doc/BRIEF.md
# Charge-Pump Fast-Lock Timer Controller

This block decides, cycle by cycle, whether a charge-pump PLL runs with its boosted loop (high pump current, loop-filter switch driven low) or its normal loop (low pump current, switch released to high impedance). A register write delivers four fields in one strobe: a pump gain bit, a fast-lock enable, a mode select and a 4-bit timer code. These choose one of three behaviours. With fast lock disabled, the switch pin is a plain general-purpose output. In held mode, software starts and ends the boost with the gain bit. In timed mode, setting the gain bit starts a countdown of phase-detector reference periods, and at the end the block clears the gain bit by itself.

The timer advances only on a phase-detector-rate enable pulse (`ref_tick`), never on bare system clocks. Its length is 3 + 4 x code ticks, so it runs from 3 to 63 periods. A power-down input aborts any countdown and holds every output idle. The switch pin is modelled as a drive enable plus a drive value, so the pad logic can build a tri-state output from them.

Top module: `fastlock_ctrl`

## Requirements
- R1: After reset all fields read zero, so `cp_hi`=0 (low current), `sw_oe`=1 and `sw_val`=0 (switch driven low as a general-purpose output).
- R2: With enable 0 and no power-down, `sw_oe`=1 and `sw_val` equals the mode bit, while `cp_hi` equals the gain bit.
- R3: With enable 1, mode 0 and no power-down, gain 1 gives `cp_hi`=1, `sw_oe`=1, `sw_val`=0, and gain 0 gives `cp_hi`=0, `sw_oe`=0, `sw_val`=0.
- R4: In timed mode (enable 1, mode 1), a write with gain 1 gives `cp_hi`=1, `sw_oe`=1, `sw_val`=0 from the cycle after the write strobe.
- R5: The timed boost lasts exactly 3 + 4 x code `ref_tick` pulses. Clock cycles without `ref_tick` do not advance it.
- R6: On the last tick the gain bit clears by itself. From the next cycle `cp_hi`=0 and `sw_oe`=0, and they stay so under further ticks.
- R7: A new gain-1 write in timed mode while the timer runs restarts the count from zero.
- R8: While `pd` is high, `cp_hi`=0 and `sw_oe`=0, and any countdown is cancelled. In timed mode the gain bit is cleared, so the outputs stay idle after `pd` falls. In general-purpose mode the outputs resume after `pd` falls.
- R9: A timed-mode write with gain 0 ends a running boost at once. Later ticks do not bring it back.
- R10: A `ref_tick` in the same cycle as a starting write is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pd | input | 1 | Power-down; forces idle outputs and cancels the timer |
| wr_stb | input | 1 | One-cycle strobe that loads the four fields |
| wr_gain | input | 1 | Pump gain bit: 1 high current, 0 low current |
| wr_en | input | 1 | Fast-lock enable |
| wr_mode | input | 1 | Mode select: GPO level when disabled, 1 = timed when enabled |
| wr_code | input | 4 | Timer code; length 3 + 4 x code ticks |
| ref_tick | input | 1 | One-cycle pulse at phase-detector rate |
| cp_hi | output | 1 | Effective pump current select (1 = high) |
| sw_oe | output | 1 | Switch drive enable (0 = high impedance) |
| sw_val | output | 1 | Switch drive level when enabled |

## Verification
The timed mode is tried with codes 0, 2 and 15. A check one tick before the end and a check on the final tick separate an off-by-one in the length formula from a correct count. Long runs of clocks with no tick show that only `ref_tick` advances the timer. A restart partway through a countdown and a write that lands on a tick both separate restart-from-zero from carrying the old count forward. Power-down is applied once in general-purpose mode and once mid-countdown, which shows the difference between outputs that are only masked and a gain bit that is truly cleared.

// File: rtl/fastlock_pkg.sv
package fastlock_pkg;

    localparam int FL_CODE_W = 4;

    typedef enum logic [1:0] {
        FL_GPO   = 2'd0,
        FL_HELD  = 2'd1,
        FL_TIMED = 2'd2
    } fl_mode_e;

    typedef struct packed {
        logic                 gain;
        logic                 en;
        logic                 sel;
        logic [FL_CODE_W-1:0] code;
    } fl_cfg_t;

    typedef struct packed {
        logic cp_hi;
        logic oe;
        logic val;
    } fl_drive_t;

    function automatic fl_mode_e fl_mode_of(fl_cfg_t c);
        if (!c.en)     return FL_GPO;
        else if (c.sel) return FL_TIMED;
        else            return FL_HELD;
    endfunction

    function automatic int unsigned fl_span(int unsigned base, int unsigned step,
                                            logic [FL_CODE_W-1:0] code);
        return base + step * int'(code);
    endfunction

endpackage

// File: rtl/fastlock_cfg.sv
module fastlock_cfg
    import fastlock_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pd,
    input  logic    wr_stb,
    input  fl_cfg_t wr_cfg,
    input  logic    expire,
    output fl_cfg_t cfg_q,
    output logic    tmr_start,
    output logic    tmr_abort
);
    fl_cfg_t nxt;

    always_comb begin
        tmr_start = wr_stb && !pd && wr_cfg.gain && (fl_mode_of(wr_cfg) == FL_TIMED);
        tmr_abort = pd || (wr_stb && !tmr_start);
    end

    always_comb begin
        nxt = wr_stb ? wr_cfg : cfg_q;
        if (expire && !wr_stb)
            nxt.gain = 1'b0;
        if (pd && fl_mode_of(nxt) == FL_TIMED)
            nxt.gain = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= nxt;
    end
endmodule

// File: rtl/fastlock_timer.sv
module fastlock_timer
    import fastlock_pkg::*;
#(
    parameter int TMR_BASE = 3,
    parameter int TMR_STEP = 4,
    parameter int CNT_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 abort,
    input  logic                 tick,
    input  logic [FL_CODE_W-1:0] code,
    output logic                 run,
    output logic [CNT_W-1:0]     cnt,
    output logic                 expire
);
    logic [CNT_W-1:0] last;

    always_comb begin
        last   = CNT_W'(fl_span(TMR_BASE, TMR_STEP, code) - 1);
        expire = run && tick && !start && !abort && (cnt == last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (abort || expire) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fastlock_drive.sv
module fastlock_drive
    import fastlock_pkg::*;
(
    input  fl_cfg_t   cfg,
    input  logic      run,
    input  logic      pd,
    output fl_drive_t drv
);
    logic boost;

    always_comb begin
        drv   = '0;
        boost = 1'b0;
        if (!pd) begin
            drv.cp_hi = cfg.gain;
            unique case (fl_mode_of(cfg))
                FL_GPO: begin
                    drv.oe  = 1'b1;
                    drv.val = cfg.sel;
                end
                FL_HELD:  boost = cfg.gain;
                FL_TIMED: boost = run;
                default:  boost = 1'b0;
            endcase
            if (boost) begin
                drv.oe  = 1'b1;
                drv.val = 1'b0;
            end
        end
    end
endmodule

// File: rtl/fastlock_ctrl.sv
module fastlock_ctrl
    import fastlock_pkg::*;
#(
    parameter int TMR_BASE = 3,
    parameter int TMR_STEP = 4,
    localparam int CNT_W   = $clog2(TMR_BASE + TMR_STEP * ((1 << FL_CODE_W) - 1) + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pd,
    input  logic                 wr_stb,
    input  logic                 wr_gain,
    input  logic                 wr_en,
    input  logic                 wr_mode,
    input  logic [FL_CODE_W-1:0] wr_code,
    input  logic                 ref_tick,
    output logic                 cp_hi,
    output logic                 sw_oe,
    output logic                 sw_val
);
    fl_cfg_t          wr_cfg;
    fl_cfg_t          cfg_q;
    fl_drive_t        drv;
    logic             tmr_start;
    logic             tmr_abort;
    logic             tmr_run;
    logic             tmr_expire;
    logic [CNT_W-1:0] tmr_cnt;

    assign wr_cfg = '{gain: wr_gain, en: wr_en, sel: wr_mode, code: wr_code};

    fastlock_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .pd        (pd),
        .wr_stb    (wr_stb),
        .wr_cfg    (wr_cfg),
        .expire    (tmr_expire),
        .cfg_q     (cfg_q),
        .tmr_start (tmr_start),
        .tmr_abort (tmr_abort)
    );

    fastlock_timer #(
        .TMR_BASE (TMR_BASE),
        .TMR_STEP (TMR_STEP),
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (tmr_start),
        .abort  (tmr_abort),
        .tick   (ref_tick),
        .code   (cfg_q.code),
        .run    (tmr_run),
        .cnt    (tmr_cnt),
        .expire (tmr_expire)
    );

    fastlock_drive u_drive (
        .cfg (cfg_q),
        .run (tmr_run),
        .pd  (pd),
        .drv (drv)
    );

    assign cp_hi  = drv.cp_hi;
    assign sw_oe  = drv.oe;
    assign sw_val = drv.val;
endmodule

// File: rtl/fastlock_ctrl_chk.sv
module fastlock_ctrl_chk
    import fastlock_pkg::*;
#(
    parameter int TMR_BASE = 3,
    parameter int TMR_STEP = 4,
    parameter int CNT_W    = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             pd,
    input logic             cp_hi,
    input logic             sw_oe,
    input logic             sw_val,
    input fl_cfg_t          cfg_q,
    input logic             tmr_start,
    input logic             tmr_run,
    input logic             tmr_expire,
    input logic [CNT_W-1:0] tmr_cnt
);
    p_gpo_level_r2: assert property (@(posedge clk) disable iff (rst)
        (!pd && !cfg_q.en) |-> (sw_oe && sw_val == cfg_q.sel && cp_hi == cfg_q.gain));

    p_boost_pair_r3: assert property (@(posedge clk) disable iff (rst)
        (!pd && cfg_q.en) |-> (cp_hi == sw_oe && !sw_val));

    p_start_loads_r4: assert property (@(posedge clk) disable iff (rst)
        tmr_start |=> (tmr_run && tmr_cnt == '0 && cfg_q.gain));

    p_cnt_in_window_r5: assert property (@(posedge clk) disable iff (rst)
        tmr_run |-> (int'(tmr_cnt) < TMR_BASE + TMR_STEP * int'(cfg_q.code)));

    p_expire_clears_r6: assert property (@(posedge clk) disable iff (rst)
        tmr_expire |=> (!cfg_q.gain && !tmr_run));

    p_timed_gain_tracks_run_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.en && cfg_q.sel) |-> (cfg_q.gain == tmr_run));

    p_pd_idle_r8: assert property (@(posedge clk) disable iff (rst)
        pd |-> (!cp_hi && !sw_oe));

    p_pd_stops_timer_r8: assert property (@(posedge clk) disable iff (rst)
        pd |=> !tmr_run);
endmodule

bind fastlock_ctrl fastlock_ctrl_chk #(
    .TMR_BASE (TMR_BASE),
    .TMR_STEP (TMR_STEP),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pd         (pd),
    .cp_hi      (cp_hi),
    .sw_oe      (sw_oe),
    .sw_val     (sw_val),
    .cfg_q      (cfg_q),
    .tmr_start  (tmr_start),
    .tmr_run    (tmr_run),
    .tmr_expire (tmr_expire),
    .tmr_cnt    (tmr_cnt)
);

// File: tb/fastlock_ctrl_tb.sv
module fastlock_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pd = 1'b0;
    logic       wr_stb = 1'b0;
    logic       wr_gain = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_mode = 1'b0;
    logic [3:0] wr_code = '0;
    logic       ref_tick = 1'b0;
    logic       cp_hi, sw_oe, sw_val;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [2:0] OUT_IDLE  = 3'b000;
    localparam logic [2:0] OUT_BOOST = 3'b110;

    always #10ns clk = ~clk;

    fastlock_ctrl u_dut (
        .clk(clk), .rst(rst), .pd(pd), .wr_stb(wr_stb), .wr_gain(wr_gain),
        .wr_en(wr_en), .wr_mode(wr_mode), .wr_code(wr_code),
        .ref_tick(ref_tick), .cp_hi(cp_hi), .sw_oe(sw_oe), .sw_val(sw_val)
    );

    task automatic check(string req, logic [2:0] exp);
        logic [2:0] act;
        act = {cp_hi, sw_oe, sw_val};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {cp_hi,sw_oe,sw_val} actual %b expected %b at %0t",
                     req, act, exp, $time);
        end
    endtask

    task automatic write(logic g, logic e, logic m, logic [3:0] c, logic with_tick = 1'b0);
        @(negedge clk);
        wr_stb = 1'b1; wr_gain = g; wr_en = e; wr_mode = m; wr_code = c;
        ref_tick = with_tick;
        @(negedge clk);
        wr_stb = 1'b0; ref_tick = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        check("R1 reset state", 3'b010);
    endtask

    task automatic t_gpo();
        write(1'b0, 1'b0, 1'b1, 4'd0);
        check("R2 gpo high, gain 0", 3'b011);
        write(1'b1, 1'b0, 1'b0, 4'd0);
        check("R2 gpo low, gain 1", 3'b110);
        write(1'b1, 1'b0, 1'b1, 4'd0);
        check("R2 gpo high, gain 1", 3'b111);
    endtask

    task automatic t_held();
        write(1'b1, 1'b1, 1'b0, 4'd0);
        check("R3 held gain 1", OUT_BOOST);
        ticks(70);
        check("R3 held ignores timer", OUT_BOOST);
        write(1'b0, 1'b1, 1'b0, 4'd0);
        check("R3 held gain 0", OUT_IDLE);
    endtask

    task automatic t_timed(logic [3:0] code);
        int len = 3 + 4 * int'(code);
        write(1'b1, 1'b1, 1'b1, code);
        check("R4 timed start", OUT_BOOST);
        repeat (30) @(negedge clk);
        check("R5 clocks without tick do not count", OUT_BOOST);
        ticks(len - 1);
        check("R5 one tick before end", OUT_BOOST);
        ticks(1);
        check("R6 expired on last tick", OUT_IDLE);
        ticks(5);
        check("R6 stays idle after expiry", OUT_IDLE);
    endtask

    task automatic t_restart();
        write(1'b1, 1'b1, 1'b1, 4'd1);
        ticks(5);
        write(1'b1, 1'b1, 1'b1, 4'd1);
        ticks(6);
        check("R7 restart counts from zero", OUT_BOOST);
        ticks(1);
        check("R7 expiry after restart", OUT_IDLE);
    endtask

    task automatic t_same_cycle();
        write(1'b1, 1'b1, 1'b1, 4'd0, 1'b1);
        ticks(2);
        check("R10 tick at start not counted", OUT_BOOST);
        ticks(1);
        check("R10 expiry after three ticks", OUT_IDLE);
    endtask

    task automatic t_cancel();
        write(1'b1, 1'b1, 1'b1, 4'd3);
        ticks(2);
        write(1'b0, 1'b1, 1'b1, 4'd3);
        check("R9 gain 0 ends boost", OUT_IDLE);
        ticks(20);
        check("R9 stays idle", OUT_IDLE);
    endtask

    task automatic t_pd();
        write(1'b1, 1'b0, 1'b1, 4'd0);
        @(negedge clk); pd = 1'b1;
        @(negedge clk);
        check("R8 pd idles gpo", OUT_IDLE);
        pd = 1'b0;
        @(negedge clk);
        check("R8 gpo resumes after pd", 3'b111);
        write(1'b1, 1'b1, 1'b1, 4'd2);
        ticks(3);
        @(negedge clk); pd = 1'b1;
        @(negedge clk);
        check("R8 pd idles timed boost", OUT_IDLE);
        pd = 1'b0;
        @(negedge clk);
        check("R8 gain cleared by pd", OUT_IDLE);
        ticks(12);
        check("R8 no resume after pd", OUT_IDLE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_gpo();
        t_held();
        t_timed(4'd0);
        t_timed(4'd2);
        t_timed(4'd15);
        t_restart();
        t_same_cycle();
        t_cancel();
        t_pd();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule